// File: doc/BRIEF.md
# Two-Dimensional Parity Protected Memory

A synchronous, word-addressed storage array guarded by two independent parity codes. Along each word, a bit-interleaved horizontal code keeps `PAR_N` check bits. Check bit `i` is the XOR of every data bit whose position modulo `PAR_N` equals `i`, so any run of up to `PAR_N` adjacent flipped bits changes at least one check bit. Across words, a small bank of `VP_ROWS` vertical parity rows holds the XOR of all data rows that share a row index modulo `VP_ROWS`. Correction hardware can later use these rows to rebuild a row that the horizontal code rejects.

Every write is turned into a read-before-write. In the first cycle the old word is read. In the second cycle the new word and its check bits are stored, and the difference between old and new is passed to a pipelined update stage. That stage folds the difference into the selected vertical row one cycle later. Every read recomputes the horizontal code and compares it with the stored code. A mismatch is flagged on the read response and latched, together with the failing address, in a sticky status register. A debug port reads any vertical row. A test-only injection request flips stored data bits without touching either code, so that the error path can be exercised.

Top module: `tdp_mem`

## Requirements
- R1: After reset every data row reads as zero with no error, every vertical row reads zero, `req_ready_o` is 1, and `rd_valid_o`, `rd_err_o` and `err_flag_o` are 0.
- R2: The stored check bits of a word are computed from the written word alone, with check bit i equal to the XOR of data bits j where j mod PAR_N equals i. Any contiguous flip of 1 to PAR_N data bits is reported as an error. Flipping exactly two bits PAR_N apart (bits 0 and 8 at the default) is not reported.
- R3: An accepted write (`req_we_i`=1, `req_inj_i`=0) drives `req_ready_o` low for exactly the next cycle. A request held during that cycle is not accepted. A read accepted right after the write returns the new data.
- R4: After each write has drained, vertical row k equals the XOR of all data rows whose index mod VP_ROWS equals k. VP_ROWS is a power of two, so the index is the low address bits. The rows are read on `dbg_vp_row_o` by selecting `dbg_vp_idx_i`.
- R5: Rewriting a row with the data it already holds leaves every vertical row unchanged.
- R6: A read accepted in cycle t raises `rd_valid_o` for one cycle in cycle t+1, with `rd_data_o` holding the stored word.
- R7: `rd_err_o` is 1 together with `rd_valid_o` when the recomputed and stored check bits differ. The first such read sets `err_flag_o` and loads its address into `err_addr_o` on the next edge. Later errors leave the address unchanged until `err_clr_i` clears the flag. A new error in the same cycle as a clear wins.
- R8: An injection request (`req_inj_i`=1) XORs `req_wdata_i` into the stored data of `req_addr_i` in one cycle, keeps `req_ready_o` high, and changes neither the check bits nor any vertical row.
- R9: A write request held continuously is accepted on every second cycle. Two back-to-back writes to rows in the same vertical class both fold into that vertical row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_inj_i | input | 1 | Fault injection: XOR `req_wdata_i` into the stored word |
| req_addr_i | input | ADDR_W (6) | Row address |
| req_wdata_i | input | DATA_W (64) | Write data or injection mask |
| req_ready_o | output | 1 | Request accepted when high with `req_valid_i` |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | DATA_W (64) | Read data |
| rd_err_o | output | 1 | Horizontal check mismatch on this response |
| err_clr_i | input | 1 | Clear sticky error status |
| err_flag_o | output | 1 | Sticky error flag |
| err_addr_o | output | ADDR_W (6) | Address of the first failing read |
| dbg_vp_idx_i | input | VP_W (5) | Vertical row select |
| dbg_vp_row_o | output | DATA_W (64) | Selected vertical row |

## Verification
The bench aims at the interleave: bursts of every length up to the group width at several offsets must be caught, while a pair of flips inside one parity group must slip through. A code that used plain byte parity or a wrong stride fails one of those two cases. Rows 3 and 35 share a vertical class and are written back to back, and a row is rewritten with identical data. An update stage that drops, repeats or misroutes a difference leaves a vertical row off from the XOR model. A request is held through the write cycle, so a design that accepts it twice or never lowers ready is exposed. A second error is raised while the status is still set, so a design that overwrites the captured address is seen.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } tdp_state_e;
endpackage

// File: rtl/tdp_hcode_enc.sv
module tdp_hcode_enc #(
  parameter int DATA_W = 64,
  parameter int PAR_N  = 8
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [PAR_N-1:0]  chk_o
);
  for (genvar i = 0; i < PAR_N; i++) begin : g_chk
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int j = i; j < DATA_W; j += PAR_N) acc ^= data_i[j];
    end
    assign chk_o[i] = acc;
  end
endmodule

// File: rtl/tdp_vpar_bank.sv
module tdp_vpar_bank #(
  parameter int DATA_W  = 64,
  parameter int VP_ROWS = 32,
  localparam int VP_W   = $clog2(VP_ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_v_i,
  input  logic [VP_W-1:0]   upd_idx_i,
  input  logic [DATA_W-1:0] upd_diff_i,
  input  logic [VP_W-1:0]   dbg_idx_i,
  output logic [DATA_W-1:0] dbg_row_o
);
  logic              upd_v_q;
  logic [VP_W-1:0]   upd_idx_q;
  logic [DATA_W-1:0] upd_diff_q;
  logic [DATA_W-1:0] rows_q [VP_ROWS];

  // stage register keeps the fold off the array path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_v_q    <= 1'b0;
      upd_idx_q  <= '0;
      upd_diff_q <= '0;
    end else begin
      upd_v_q    <= upd_v_i;
      upd_idx_q  <= upd_idx_i;
      upd_diff_q <= upd_diff_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < VP_ROWS; k++) rows_q[k] <= '0;
    end else if (upd_v_q) begin
      rows_q[upd_idx_q] <= rows_q[upd_idx_q] ^ upd_diff_q;
    end
  end

  assign dbg_row_o = rows_q[dbg_idx_i];

  p_vrow_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(dbg_idx_i) && !$past(upd_v_q)) |-> $stable(dbg_row_o));
endmodule

// File: rtl/tdp_mem.sv
module tdp_mem
  import tdp_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int PAR_N   = 8,
  parameter int ROWS    = 64,
  parameter int VP_ROWS = 32,
  localparam int ADDR_W = $clog2(ROWS),
  localparam int VP_W   = $clog2(VP_ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic              req_inj_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_err_o,
  input  logic              err_clr_i,
  output logic              err_flag_o,
  output logic [ADDR_W-1:0] err_addr_o,
  input  logic [VP_W-1:0]   dbg_vp_idx_i,
  output logic [DATA_W-1:0] dbg_vp_row_o
);
  tdp_state_e        state_q;
  logic [DATA_W-1:0] mem_q [ROWS];
  logic [PAR_N-1:0]  chk_q [ROWS];
  logic [ADDR_W-1:0] wr_addr_q, rd_addr_q, err_addr_q;
  logic [DATA_W-1:0] wr_data_q, old_q, rd_data_q;
  logic [PAR_N-1:0]  rd_chk_q, wr_chk, rd_chk_calc;
  logic              rd_valid_q, err_flag_q;
  logic              accept, wr_go, rd_go, inj_go;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign inj_go      = accept && req_inj_i;
  assign wr_go       = accept && req_we_i && !req_inj_i;
  assign rd_go       = accept && !req_we_i && !req_inj_i;

  tdp_hcode_enc #(.DATA_W(DATA_W), .PAR_N(PAR_N)) i_enc_wr (
    .data_i(wr_data_q), .chk_o(wr_chk));
  tdp_hcode_enc #(.DATA_W(DATA_W), .PAR_N(PAR_N)) i_enc_rd (
    .data_i(rd_data_q), .chk_o(rd_chk_calc));

  // phase 1: capture request and old word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      old_q     <= '0;
    end else if (wr_go) begin
      state_q   <= ST_WRITE;
      wr_addr_q <= req_addr_i;
      wr_data_q <= req_wdata_i;
      old_q     <= mem_q[req_addr_i];
    end else begin
      state_q   <= ST_IDLE;
    end
  end

  // phase 2: store word and code; injection only flips data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) begin
        mem_q[r] <= '0;
        chk_q[r] <= '0;
      end
    end else if (state_q == ST_WRITE) begin
      mem_q[wr_addr_q] <= wr_data_q;
      chk_q[wr_addr_q] <= wr_chk;
    end else if (inj_go) begin
      mem_q[req_addr_i] <= mem_q[req_addr_i] ^ req_wdata_i;
    end
  end

  tdp_vpar_bank #(.DATA_W(DATA_W), .VP_ROWS(VP_ROWS)) i_vpar (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_v_i    ((state_q == ST_WRITE) && (old_q != wr_data_q)),
    .upd_idx_i  (wr_addr_q[VP_W-1:0]),
    .upd_diff_i (old_q ^ wr_data_q),
    .dbg_idx_i  (dbg_vp_idx_i),
    .dbg_row_o  (dbg_vp_row_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      rd_chk_q   <= '0;
      rd_addr_q  <= '0;
    end else begin
      rd_valid_q <= rd_go;
      if (rd_go) begin
        rd_data_q <= mem_q[req_addr_i];
        rd_chk_q  <= chk_q[req_addr_i];
        rd_addr_q <= req_addr_i;
      end
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign rd_err_o   = rd_valid_q && (rd_chk_calc != rd_chk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_flag_q <= 1'b0;
      err_addr_q <= '0;
    end else if (rd_err_o && (!err_flag_q || err_clr_i)) begin
      err_flag_q <= 1'b1;
      err_addr_q <= rd_addr_q;
    end else if (err_clr_i) begin
      err_flag_q <= 1'b0;
    end
  end

  assign err_flag_o = err_flag_q;
  assign err_addr_o = err_addr_q;

  p_wr_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_we_i && !req_inj_i) |=> !req_ready_o);
  p_stall_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> req_ready_o);
  p_rd_resp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_we_i && !req_inj_i) |=> rd_valid_o);
  p_err_on_resp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> rd_valid_o);
  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flag_o && !err_clr_i) |=> (err_flag_o && $stable(err_addr_o)));
  p_err_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_flag_o) |-> $past(rd_err_o));
  p_inj_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_inj_i) |=> req_ready_o);
endmodule

// File: tb/test_tdp_mem.sv
module test_tdp_mem;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 64, ROWS = 64, VP_ROWS = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_we = 0, req_inj = 0, err_clr = 0;
  logic [5:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rd_valid, rd_err, err_flag;
  logic [DATA_W-1:0] rd_data, dbg_row;
  logic [5:0] err_addr;
  logic [4:0] dbg_idx = '0;

  logic [DATA_W-1:0] mdl [ROWS];
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdp_mem i_tdp_mem (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_inj_i(req_inj), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .rd_err_o(rd_err), .err_clr_i(err_clr), .err_flag_o(err_flag),
    .err_addr_o(err_addr), .dbg_vp_idx_i(dbg_idx), .dbg_vp_row_o(dbg_row));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_we = 1; req_inj = 0; req_addr = a; req_wdata = d;
    @(negedge clk);
    check(req_ready == 0, "R3 ready low in write phase", 64'(req_ready), 0);
    req_valid = 0; req_we = 0;
    @(negedge clk);
    @(negedge clk);
    mdl[a] = d;
  endtask

  task automatic do_read(input logic [5:0] a, output logic [63:0] d, output logic e);
    @(negedge clk);
    req_valid = 1; req_we = 0; req_inj = 0; req_addr = a;
    @(negedge clk);
    check(rd_valid == 1, "R6 rd_valid after read", 64'(rd_valid), 1);
    d = rd_data; e = rd_err;
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic do_inject(input logic [5:0] a, input logic [63:0] m);
    @(negedge clk);
    req_valid = 1; req_inj = 1; req_we = 0; req_addr = a; req_wdata = m;
    @(negedge clk);
    check(req_ready == 1, "R8 ready stays high on inject", 64'(req_ready), 1);
    req_valid = 0; req_inj = 0;
    @(negedge clk);
  endtask

  task automatic check_vp(input string req);
    for (int k = 0; k < VP_ROWS; k++) begin
      logic [63:0] exp = '0;
      for (int r = k; r < ROWS; r += VP_ROWS) exp ^= mdl[r];
      dbg_idx = 5'(k);
      #1;
      check(dbg_row == exp, req, dbg_row, exp);
    end
  endtask

  task automatic test_reset();
    logic [63:0] d; logic e;
    check(req_ready == 1 && rd_valid == 0 && rd_err == 0 && err_flag == 0,
          "R1 reset outputs", {req_ready, rd_valid, rd_err, err_flag}, 4'b1000);
    check_vp("R1 vertical rows zero");
    do_read(6'd5, d, e);
    check(d == 0 && e == 0, "R1 row reads zero", d, 0);
  endtask

  task automatic test_write_read();
    logic [63:0] d; logic e;
    logic [5:0] a [4] = '{6'd0, 6'd1, 6'd33, 6'd63};
    logic [63:0] v [4] = '{64'hDEAD_BEEF_0123_4567, 64'hFFFF_FFFF_FFFF_FFFF,
                           64'h8000_0000_0000_0001, 64'h5A5A_A5A5_0F0F_F0F0};
    for (int i = 0; i < 4; i++) do_write(a[i], v[i]);
    for (int i = 0; i < 4; i++) begin
      do_read(a[i], d, e);
      check(d == v[i] && e == 0, "R6 read back", d, v[i]);
    end
    // write then read immediately
    do_write(6'd1, 64'h1234_5678_9ABC_DEF0);
    do_read(6'd1, d, e);
    check(d == 64'h1234_5678_9ABC_DEF0, "R3 read sees new data", d, 64'h1234_5678_9ABC_DEF0);
    check(e == 0, "R2 code from new word", 64'(e), 0);
    check_vp("R4 vertical parity after writes");
    do_write(6'd33, 64'h0F0F_0000_1111_2222);
    check_vp("R4 vertical parity after overwrite");
  endtask

  task automatic test_same_data();
    do_write(6'd1, mdl[1]);
    do_write(6'd63, mdl[63]);
    check_vp("R5 identical rewrite keeps vertical rows");
  endtask

  task automatic test_back_to_back();
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = 6'd3; req_wdata = 64'hAAAA_0000_5555_1234;
    @(negedge clk);
    check(req_ready == 0, "R9 held request stalls", 64'(req_ready), 0);
    @(negedge clk);
    check(req_ready == 1, "R9 ready returns", 64'(req_ready), 1);
    mdl[3] = 64'hAAAA_0000_5555_1234;
    req_addr = 6'd35; req_wdata = 64'h0000_FFFF_1357_9BDF;
    @(negedge clk);
    check(req_ready == 0, "R9 second write accepted", 64'(req_ready), 0);
    req_valid = 0; req_we = 0;
    mdl[35] = 64'h0000_FFFF_1357_9BDF;
    @(negedge clk);
    @(negedge clk);
    check_vp("R9 back-to-back same class");
  endtask

  task automatic test_inject();
    logic [63:0] d; logic e;
    do_write(6'd4, 64'hCAFE_F00D_0000_0001);
    do_inject(6'd4, 64'h0000_0000_0001_0000);
    check_vp("R8 inject leaves vertical rows");
    do_read(6'd4, d, e);
    check(d == 64'hCAFE_F00D_0001_0001, "R8 inject flips data", d, 64'hCAFE_F00D_0001_0001);
    check(e == 1, "R7 rd_err on mismatch", 64'(e), 1);
    check(err_flag == 1 && err_addr == 6'd4, "R7 flag and address", {err_flag, err_addr}, {1'b1, 6'd4});
  endtask

  task automatic test_sticky();
    logic [63:0] d; logic e;
    do_inject(6'd21, 64'h0000_0100_0000_0000);
    do_read(6'd21, d, e);
    check(e == 1, "R7 second error seen", 64'(e), 1);
    check(err_addr == 6'd4, "R7 address held", 64'(err_addr), 4);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    check(err_flag == 0, "R7 clear", 64'(err_flag), 0);
    do_read(6'd21, d, e);
    check(err_flag == 1 && err_addr == 6'd21, "R7 recapture", {err_flag, err_addr}, {1'b1, 6'd21});
  endtask

  task automatic test_bursts();
    logic [63:0] d; logic e;
    for (int len = 1; len <= 8; len++) begin
      logic [63:0] m = ((64'd1 << len) - 1) << (len * 5);
      do_inject(6'(40 + len), m);
      do_read(6'(40 + len), d, e);
      check(e == 1 && d == m, "R2 burst detected", {63'(d != m), e}, 1);
    end
    do_inject(6'd50, 64'h0000_0000_0000_0101);
    do_read(6'd50, d, e);
    check(e == 0, "R2 same-group pair undetected", 64'(e), 0);
    do_inject(6'd51, 64'h0000_0000_0000_0003);
    do_read(6'd51, d, e);
    check(e == 1, "R2 adjacent pair detected", 64'(e), 1);
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_write_read();
    test_same_data();
    test_back_to_back();
    test_inject();
    test_sticky();
    test_bursts();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule